// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This unit sits in the decode stage of a five-stage in-order pipeline. It takes the decoded control-transfer fields of the instruction in decode, that instruction's address, and the two register read values. From these it decides whether control leaves the sequential path and where it goes. A private adder forms the destination, so the execute-stage ALU stays free for the instruction ahead of the branch.

The instruction fetched right behind a branch is always in the pipe already. A build-time parameter picks how that trailing instruction is treated, with one of three policies:
- Flush it when the branch is taken, and let it run otherwise.
- Always let it run, as an architectural delay slot, with the redirect applied after it.
- Let it run only when the branch is taken, and squash it otherwise.

For a delay-slot instruction, the unit also reports the address from which an exception handler must restart. All results are registered. They act on the clock edge that follows resolution and last one cycle.

The unit has no data stream. Its inputs and outputs are plain control signals, so there is no valid/ready handshake. Back-pressure comes only from the interlock through `stall`: a branch seen while `stall` is high is held in decode and resolved on the first edge with `stall` low.

Top module: `br_resolve`

## Requirements
- R1: For conditional ops, the destination is pc + 4 + (sign-extended 16-bit offset shifted left by 2), formed without any register operand.
- R2: Op JMP (code 5) targets {bits 31:28 of pc+4, 26-bit index, 2'b00}. Op JR (code 6) targets the rs value unchanged. Both are always taken.
- R3: Op codes are NONE=0, BEQ=1, BNE=2, BLTZ=3, BGEZ=4. BEQ and BNE compare all 32 bits of rs and rt. BLTZ and BGEZ test the sign of rs as a signed 32-bit value.
- R4: Outputs are zero after reset. Each result appears on the edge after the branch is accepted and lasts exactly one cycle.
- R5: Flush policy (SLOT_MODE=0): a taken branch raises redirect and kill together. A not-taken branch raises neither.
- R6: Delay policy (SLOT_MODE=1): a taken branch raises redirect, and kill is never raised. Any accepted branch raises slot_in_ds with slot_restart_pc equal to the branch's own pc.
- R7: Likely policy (SLOT_MODE=2): a taken branch raises redirect without kill. A not-taken branch raises kill without redirect.
- R8: When stall is high at an edge, the next cycle shows neither redirect nor kill. The held branch resolves once stall is low.
- R9: Op NONE, or dec_valid low, produces no redirect, no kill and no slot_in_ds.
- R10: Outside the delay policy, slot_in_ds stays low. An accepted branch sets slot_restart_pc to its pc + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds a live instruction |
| stall | input | 1 | Interlock holds decode this cycle |
| dec_op | input | 3 | Control-transfer op code |
| dec_pc | input | 32 | Address of the instruction in decode |
| dec_off | input | 16 | PC-relative word offset |
| dec_idx | input | 26 | Absolute jump word index |
| rs_val | input | 32 | First register read value |
| rt_val | input | 32 | Second register read value |
| redirect | output | 1 | Fetch must load redir_pc |
| redir_pc | output | 32 | Next fetch address |
| kill_fetch | output | 1 | Turn the trailing instruction into a NOP |
| slot_in_ds | output | 1 | Trailing instruction is a delay slot |
| slot_restart_pc | output | 32 | Restart address for the trailing instruction |

## Verification
The assertions assume that the interlock keeps the decode fields steady while `stall` is high. They also assume that `dec_op` only carries the seven listed codes. The bench drives every input on the falling edge, and it uses only legal codes. In the stall test it holds one branch unchanged across the stalled edge and then releases the stall. Three instances, one for each policy, receive identical stimulus. This lets one stimulus table exercise all policies.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_BEQ  = 3'd1,
    OP_BNE  = 3'd2,
    OP_BLTZ = 3'd3,
    OP_BGEZ = 3'd4,
    OP_JMP  = 3'd5,
    OP_JR   = 3'd6
  } br_op_e;

  localparam int SLOT_FLUSH  = 0;
  localparam int SLOT_DELAY  = 1;
  localparam int SLOT_LIKELY = 2;
endpackage

// File: rtl/br_target.sv
module br_target #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  br_pkg::br_op_e   op,
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic [IDX_W-1:0] idx,
  input  logic [XLEN-1:0]  rs,
  output logic [XLEN-1:0]  target
);
  import br_pkg::*;
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int HI_W  = XLEN - IDX_W - 2;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_off;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] abs_tgt;

  // dedicated adder: no register operand feeds it
  assign seq_pc  = pc + XLEN'(4);
  assign rel_off = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
  assign rel_tgt = seq_pc + rel_off;
  assign abs_tgt = {seq_pc[XLEN-1 -: HI_W], idx, 2'b00};

  always_comb begin
    unique case (op)
      OP_JMP:  target = abs_tgt;
      OP_JR:   target = rs;
      default: target = rel_tgt;
    endcase
  end
endmodule

// File: rtl/br_cond.sv
module br_cond #(
  parameter int XLEN = 32
) (
  input  br_pkg::br_op_e  op,
  input  logic [XLEN-1:0] rs,
  input  logic [XLEN-1:0] rt,
  output logic            taken
);
  import br_pkg::*;
  logic same;
  logic neg;

  assign same = (rs == rt);
  assign neg  = rs[XLEN-1];

  always_comb begin
    unique case (op)
      OP_BEQ:  taken = same;
      OP_BNE:  taken = !same;
      OP_BLTZ: taken = neg;
      OP_BGEZ: taken = !neg;
      OP_JMP:  taken = 1'b1;
      OP_JR:   taken = 1'b1;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (op == OP_BEQ || op == OP_BNE)
      assert_eq_full_width_R3: assert (taken == ((op == OP_BEQ) == same));
  end
endmodule

// File: rtl/br_slot_policy.sv
module br_slot_policy #(
  parameter int SLOT_MODE = 0
) (
  input  logic fire,
  input  logic taken,
  output logic redirect_d,
  output logic kill_d,
  output logic ds_d
);
  import br_pkg::*;
  generate
    if (SLOT_MODE == SLOT_DELAY) begin : g_delay
      always_comb begin
        redirect_d = fire && taken;
        kill_d     = 1'b0;
        ds_d       = fire;
      end
    end else if (SLOT_MODE == SLOT_LIKELY) begin : g_likely
      always_comb begin
        redirect_d = fire && taken;
        kill_d     = fire && !taken;
        ds_d       = 1'b0;
      end
    end else begin : g_flush
      always_comb begin
        redirect_d = fire && taken;
        kill_d     = fire && taken;
        ds_d       = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/br_resolve.sv
module br_resolve #(
  parameter int SLOT_MODE = 0,
  parameter int XLEN      = 32,
  parameter int OFF_W     = 16,
  parameter int IDX_W     = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic             stall,
  input  logic [2:0]       dec_op,
  input  logic [XLEN-1:0]  dec_pc,
  input  logic [OFF_W-1:0] dec_off,
  input  logic [IDX_W-1:0] dec_idx,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic             redirect,
  output logic [XLEN-1:0]  redir_pc,
  output logic             kill_fetch,
  output logic             slot_in_ds,
  output logic [XLEN-1:0]  slot_restart_pc
);
  import br_pkg::*;

  br_op_e          op;
  logic            fire;
  logic            taken;
  logic [XLEN-1:0] target;
  logic            redirect_d;
  logic            kill_d;
  logic            ds_d;

  assign op   = br_op_e'(dec_op);
  assign fire = dec_valid && !stall && (op != OP_NONE);

  br_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_target (
    .op(op), .pc(dec_pc), .off(dec_off), .idx(dec_idx), .rs(rs_val), .target(target)
  );

  br_cond #(.XLEN(XLEN)) u_cond (
    .op(op), .rs(rs_val), .rt(rt_val), .taken(taken)
  );

  br_slot_policy #(.SLOT_MODE(SLOT_MODE)) u_policy (
    .fire(fire), .taken(taken), .redirect_d(redirect_d), .kill_d(kill_d), .ds_d(ds_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect        <= 1'b0;
      kill_fetch      <= 1'b0;
      slot_in_ds      <= 1'b0;
      redir_pc        <= '0;
      slot_restart_pc <= '0;
    end else begin
      redirect   <= redirect_d;
      kill_fetch <= kill_d;
      slot_in_ds <= ds_d;
      if (redirect_d) redir_pc <= target;
      if (fire)
        slot_restart_pc <= (SLOT_MODE == SLOT_DELAY) ? dec_pc : dec_pc + XLEN'(4);
    end
  end

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!redirect && !kill_fetch));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_valid || dec_op == 3'd0) |=> (!redirect && !kill_fetch && !slot_in_ds));

  generate
    if (SLOT_MODE == SLOT_DELAY) begin : g_chk_delay
      assert_delay_no_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !kill_fetch);
      assert_delay_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slot_in_ds |-> slot_restart_pc == $past(dec_pc));
    end else if (SLOT_MODE == SLOT_LIKELY) begin : g_chk_likely
      assert_likely_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(redirect && kill_fetch));
    end else begin : g_chk_flush
      assert_flush_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        redirect == kill_fetch);
    end
  endgenerate

  if (SLOT_MODE != SLOT_DELAY) begin : g_chk_nods
    assert_no_ds_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_in_ds);
  end
endmodule

// File: tb/br_resolve_tb.sv
module br_resolve_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic stall = 1'b0;
  logic [2:0] dec_op = 3'd0;
  logic [31:0] dec_pc = '0;
  logic [15:0] dec_off = '0;
  logic [25:0] dec_idx = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;

  logic red0, kill0, ds0, red1, kill1, ds1, red2, kill2, ds2;
  logic [31:0] pc0, rp0, pc1, rp1, pc2, rp2;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  br_resolve #(.SLOT_MODE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .stall(stall), .dec_op(dec_op),
    .dec_pc(dec_pc), .dec_off(dec_off), .dec_idx(dec_idx), .rs_val(rs_val), .rt_val(rt_val),
    .redirect(red0), .redir_pc(pc0), .kill_fetch(kill0), .slot_in_ds(ds0), .slot_restart_pc(rp0));
  br_resolve #(.SLOT_MODE(1)) u_dut_ds (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .stall(stall), .dec_op(dec_op),
    .dec_pc(dec_pc), .dec_off(dec_off), .dec_idx(dec_idx), .rs_val(rs_val), .rt_val(rt_val),
    .redirect(red1), .redir_pc(pc1), .kill_fetch(kill1), .slot_in_ds(ds1), .slot_restart_pc(rp1));
  br_resolve #(.SLOT_MODE(2)) u_dut_lk (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .stall(stall), .dec_op(dec_op),
    .dec_pc(dec_pc), .dec_off(dec_off), .dec_idx(dec_idx), .rs_val(rs_val), .rt_val(rt_val),
    .redirect(red2), .redir_pc(pc2), .kill_fetch(kill2), .slot_in_ds(ds2), .slot_restart_pc(rp2));

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] pc;
    logic [15:0] off;
    logic [25:0] idx;
    logic [31:0] rs;
    logic [31:0] rt;
    logic        tk;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t [0:NV-1] VEC = '{
    '{3'd1, 32'h0000_1000, 16'h0010, 26'h0, 32'h5, 32'h5, 1'b1},
    '{3'd1, 32'h0000_1000, 16'h0010, 26'h0, 32'h5, 32'h8000_0005, 1'b0},
    '{3'd2, 32'h0000_2000, 16'h0004, 26'h0, 32'h5, 32'h8000_0005, 1'b1},
    '{3'd2, 32'h0000_2000, 16'h0004, 26'h0, 32'h7, 32'h7, 1'b0},
    '{3'd3, 32'h0000_3000, 16'hFFFC, 26'h0, 32'h8000_0000, 32'h0, 1'b1},
    '{3'd3, 32'h0000_3000, 16'hFFFC, 26'h0, 32'h0, 32'h0, 1'b0},
    '{3'd4, 32'h0000_4000, 16'h0100, 26'h0, 32'h0, 32'h0, 1'b1},
    '{3'd4, 32'h0000_4000, 16'h0100, 26'h0, 32'hFFFF_FFFF, 32'h0, 1'b0},
    '{3'd5, 32'hA000_0100, 16'h0000, 26'h0000123, 32'h0, 32'h0, 1'b1},
    '{3'd6, 32'h0000_5000, 16'h0000, 26'h0, 32'h0000_2003, 32'h0, 1'b1},
    '{3'd0, 32'h0000_6000, 16'h0000, 26'h0, 32'h0, 32'h0, 1'b0}
  };

  function automatic logic [31:0] exp_target(vec_t v);
    logic [31:0] nxt;
    nxt = v.pc + 32'd4;
    if (v.op == 3'd5) return {nxt[31:28], v.idx, 2'b00};
    if (v.op == 3'd6) return v.rs;
    return nxt + {{14{v.off[15]}}, v.off, 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    dec_op = v.op; dec_pc = v.pc; dec_off = v.off; dec_idx = v.idx;
    rs_val = v.rs; rt_val = v.rt; dec_valid = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R4 reset state
    chk("R4 reset redirect", {29'd0, red0, red1, red2}, 32'd0);
    chk("R4 reset kill", {29'd0, kill0, kill1, kill2}, 32'd0);
    chk("R4 reset ds", {29'd0, ds0, ds1, ds2}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic fire;
      logic [31:0] tgt;
      fire = (VEC[i].op != 3'd0);
      tgt  = exp_target(VEC[i]);
      apply(VEC[i]);
      @(negedge clk);
      // R1 R2 R3 via redirect and target; R5 R6 R7 R9 R10 per policy
      chk("R5 flush redirect", {31'd0, red0}, {31'd0, VEC[i].tk});
      chk("R5 flush kill", {31'd0, kill0}, {31'd0, VEC[i].tk});
      chk("R6 delay redirect", {31'd0, red1}, {31'd0, VEC[i].tk});
      chk("R6 delay kill", {31'd0, kill1}, 32'd0);
      chk("R6 delay ds flag", {31'd0, ds1}, {31'd0, fire});
      chk("R7 likely redirect", {31'd0, red2}, {31'd0, VEC[i].tk});
      chk("R7 likely kill", {31'd0, kill2}, {31'd0, fire && !VEC[i].tk});
      chk("R10 no ds flag", {30'd0, ds0, ds2}, 32'd0);
      if (VEC[i].tk) begin
        chk("R1 R2 target", pc0, tgt);
        chk("R1 R2 target likely", pc2, tgt);
        chk("R3 condition target delay", pc1, tgt);
      end
      if (fire) begin
        chk("R6 restart pc", rp1, VEC[i].pc);
        chk("R10 restart pc", rp0, VEC[i].pc + 32'd4);
      end
      dec_valid = 1'b0;
      dec_op = 3'd0;
      @(negedge clk);
      chk("R4 one cycle pulse", {29'd0, red0, red1, red2}, 32'd0);
    end

    // R8: stalled branch gives nothing, then resolves on release
    apply(VEC[0]);
    stall = 1'b1;
    @(negedge clk);
    chk("R8 stalled redirect", {29'd0, red0, red1, red2}, 32'd0);
    chk("R8 stalled kill", {29'd0, kill0, kill1, kill2}, 32'd0);
    stall = 1'b0;
    @(negedge clk);
    chk("R8 released redirect", {29'd0, red0, red1, red2}, 32'd7);
    chk("R8 released kill flush", {31'd0, kill0}, 32'd1);
    dec_valid = 1'b0;
    @(negedge clk);

    // R9: valid low with a taken op has no effect
    apply(VEC[8]);
    dec_valid = 1'b0;
    @(negedge clk);
    chk("R9 invalid redirect", {29'd0, red0, red1, red2}, 32'd0);
    chk("R9 invalid kill/ds", {28'd0, kill0, kill2, ds1, kill1}, 32'd0);

    // R4 reset clears a pending result
    apply(VEC[9]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R4 reset clears", {29'd0, red0, red1, red2}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule